// File: doc/BRIEF.md
# Speech Excitation Source

This block generates the excitation waveform that drives a vocal-tract filter in a speech synthesizer. It holds two generators that run side by side: a periodic pulse train for voiced sounds and a pseudo-random noise source for unvoiced sounds. A select input chooses which one feeds the output on each sample.

The block advances only on a sample-rate enable (`tick`). On each tick it registers one two's complement sample. It then advances the noise register and the pulse counter. The pulse period and the pulse width are programmable. New settings are taken in only at the end of a pulse period, so a pulse already in progress always completes at its full width.

Top module: `exc_source`

## Requirements
- R1: During and after synchronous reset `sample_out` is 0, the pulse counter is 0, the active period and width are 0, and the noise register holds the seed `LFSR_SEED` (default 17'h0ACE1).
- R2: `sample_out` changes only on a clock edge where `tick` is 1. It holds its value on every other edge, whatever the other inputs do. The value registered on a tick is computed from the state held before that tick.
- R3: The noise register is 17 bits, numbered 16 (MSB) down to 0. On every tick, in either mode, it shifts toward the MSB and takes bit16 XOR bit13 as its new bit 0.
- R4: When `noise_sel` is 1, a tick registers +AMP if bit 16 of the noise register is 1 and -AMP (two's complement) if it is 0. AMP defaults to 16384.
- R5: The pulse counter counts ticks from 0 to (active period − 1) and then wraps to 0. When `noise_sel` is 0, a tick registers +AMP while the count is below the active width and 0 otherwise.
- R6: An active width equal to or greater than a nonzero active period gives +AMP on every pulse-mode tick.
- R7: `period` and `duration` are copied into the active settings only on a tick where the counter wraps, or on a tick where the active period is 0. A change at any other time leaves the pulse in progress unchanged.
- R8: While the active period is 0, pulse mode registers 0 on every tick.
- R9: Both generators advance on every tick whatever the mode, and `noise_sel` is sampled anew on each tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample-rate enable |
| noise_sel | input | 1 | 1 selects noise, 0 selects the pulse train |
| period | input | PER_W | Requested pulse period in ticks (0 turns the pulse train off) |
| duration | input | PER_W | Requested pulse width in ticks |
| sample_out | output | SAMPLE_W | Registered excitation sample, two's complement |

## Verification
Each result appears at the clock edge of the tick that produces it. That tick's sample is visible just after the edge. The state advance is visible only on the following tick. The bench raises `tick` at a falling edge and drops it at the next falling edge. It compares `sample_out` at that second falling edge against a reference model that it has advanced by exactly one tick. Idle gaps with changed inputs are checked at the falling edges that follow, to confirm that the output holds. Loads of new settings are checked through the output level on the ticks after the wrap.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic {
    SRC_PULSE = 1'b0,
    SRC_NOISE = 1'b1
  } src_e;

  localparam int LFSR_W = 17;

  // one step of the x^17 + x^14 + 1 recurrence
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[16] ^ s[13]};
  endfunction

endpackage

// File: rtl/exc_lfsr.sv
module exc_lfsr
  import exc_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 17'h0ACE1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic bit_out
);

  logic [LFSR_W-1:0] state;

  always_ff @(posedge clk) begin
    if (rst)       state <= SEED;
    else if (tick) state <= lfsr_step(state);
  end

  assign bit_out = state[LFSR_W-1];

  // R3: the register must never reach the all-zero lock-up state
  assert_lfsr_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    state != '0);

  // R3: no advance without a tick
  assert_lfsr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(state));

endmodule

// File: rtl/exc_pulse.sv
module exc_pulse #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [PER_W-1:0] period_in,
  input  logic [PER_W-1:0] dur_in,
  output logic             level
);

  localparam logic [PER_W-1:0] ONE = PER_W'(1);

  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] act_per;
  logic [PER_W-1:0] act_dur;
  logic             wrap;

  assign wrap = (act_per == '0) || (cnt == act_per - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      act_per <= '0;
      act_dur <= '0;
    end else if (tick) begin
      if (wrap) begin
        cnt     <= '0;
        act_per <= period_in;
        act_dur <= dur_in;
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end

  assign level = (act_per != '0) && (cnt < act_dur);

  // R5: the count stays inside the active period
  assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    (act_per != '0) |-> (cnt < act_per));

  // R7: settings held until the wrap
  assert_hold_settings_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && !wrap) |=> ($stable(act_per) && $stable(act_dur)));

  // R8: pulse off means a zero level
  assert_off_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (act_per == '0) |-> !level);

endmodule

// File: rtl/exc_source.sv
module exc_source
  import exc_pkg::*;
#(
  parameter int                 PER_W     = 8,
  parameter int                 SAMPLE_W  = 16,
  parameter int                 AMP       = 16384,
  parameter logic [LFSR_W-1:0]  LFSR_SEED = 17'h0ACE1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                noise_sel,
  input  logic [PER_W-1:0]    period,
  input  logic [PER_W-1:0]    duration,
  output logic [SAMPLE_W-1:0] sample_out
);

  localparam logic [SAMPLE_W-1:0] POS_LVL = SAMPLE_W'(AMP);
  localparam logic [SAMPLE_W-1:0] NEG_LVL = SAMPLE_W'(-AMP);

  logic noise_bit;
  logic pulse_lvl;
  src_e src;

  assign src = src_e'(noise_sel);

  exc_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .bit_out (noise_bit)
  );

  exc_pulse #(.PER_W(PER_W)) u_pulse (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .period_in (period),
    .dur_in    (duration),
    .level     (pulse_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_out <= '0;
    end else if (tick) begin
      if (src == SRC_NOISE) sample_out <= noise_bit ? POS_LVL : NEG_LVL;
      else                  sample_out <= pulse_lvl ? POS_LVL : '0;
    end
  end

  // R2: output held between ticks
  assert_hold_out_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sample_out));

  // R4: noise samples are always one of the two levels
  assert_noise_level_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && noise_sel) |=> (sample_out == POS_LVL || sample_out == NEG_LVL));

  // R5: pulse samples are either zero or the positive level
  assert_pulse_level_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && !noise_sel) |=> (sample_out == POS_LVL || sample_out == '0));

endmodule

// File: tb/sim_exc_source.sv
`timescale 1ns/1ps
module sim_exc_source;

  localparam int PER_W = 8;
  localparam int SW    = 16;
  localparam logic [SW-1:0] POS = 16'd16384;
  localparam logic [SW-1:0] NEG = 16'hC000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic noise_sel = 1'b0;
  logic [PER_W-1:0] period = '0;
  logic [PER_W-1:0] duration = '0;
  logic [SW-1:0] sample_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [16:0]      m_lfsr = 17'h0ACE1;
  logic [PER_W-1:0] m_cnt = '0, m_per = '0, m_dur = '0;
  logic [SW-1:0]    m_out = '0;
  string            m_tag = "R1";

  always #2 clk = ~clk;

  exc_source u0 (
    .clk(clk), .rst(rst), .tick(tick), .noise_sel(noise_sel),
    .period(period), .duration(duration), .sample_out(sample_out)
  );

  task automatic chk(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    if (noise_sel) begin
      m_out = m_lfsr[16] ? POS : NEG;
      m_tag = "R4/R3";
    end else begin
      m_out = (m_per != 0 && m_cnt < m_dur) ? POS : '0;
      if (m_per == 0)          m_tag = "R8";
      else if (m_dur >= m_per) m_tag = "R6";
      else                     m_tag = "R5/R7";
    end
    m_lfsr = {m_lfsr[15:0], m_lfsr[16] ^ m_lfsr[13]};
    if (m_per == 0 || m_cnt == m_per - 8'd1) begin
      m_cnt = '0;
      m_per = period;
      m_dur = duration;
    end else begin
      m_cnt = m_cnt + 8'd1;
    end
  endtask

  // one tick, result checked just after the edge that takes it
  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    model_step();
    @(negedge clk);
    tick = 1'b0;
    chk(m_tag, sample_out, m_out);
  endtask

  // R2: idle cycles with disturbed inputs leave the output alone
  task automatic idle_gap();
    logic       s_sel = noise_sel;
    logic [7:0] s_p = period, s_d = duration;
    @(negedge clk);
    noise_sel = ~noise_sel; period = ~period; duration = ~duration;
    @(negedge clk);
    chk("R2", sample_out, m_out);
    noise_sel = s_sel; period = s_p; duration = s_d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", sample_out, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", sample_out, '0);

    // R1: first noise sample follows the seed MSB
    noise_sel = 1'b1;
    do_tick();

    // R5 R6 R7 R8 sweep over period and width
    noise_sel = 1'b0;
    for (int p = 0; p <= 5; p++) begin
      for (int d = 0; d <= 6; d++) begin
        period = 8'(p);
        duration = 8'(d);
        for (int k = 0; k < 13; k++) begin
          do_tick();
          if (k == 4) idle_gap();
          // R7: a mid-period request that should not cut the pulse
          if (k == 7) begin period = 8'(5 - p); duration = 8'(d / 2); end
          if (k == 8) begin period = 8'(p); duration = 8'(d); end
        end
      end
    end

    // R3 R4: long noise run
    noise_sel = 1'b1;
    for (int k = 0; k < 300; k++) begin
      do_tick();
      if (k % 37 == 0) idle_gap();
    end

    // R9: mode switched on every tick, both generators keep running
    period = 8'd4;
    duration = 8'd2;
    for (int k = 0; k < 40; k++) begin
      noise_sel = k[0] ^ k[2];
      do_tick();
      if (m_tag == "R5/R7") chk("R9", sample_out, m_out);
    end

    // R8: turning the pulse off takes effect at the wrap
    noise_sel = 1'b0;
    period = 8'd0;
    for (int k = 0; k < 10; k++) do_tick();
    chk("R8", sample_out, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule